// File: doc/BRIEF.md
# Floppy Head Seek and Recalibrate Sequencer

This block positions a floppy drive head on a chosen cylinder. A host-side controller gives it a one-cycle command strobe along with a command kind, an argument, a direction flag, a drive number and a head number. There are three kinds of motion command. An absolute seek moves to a given cylinder. A relative seek moves by a signed offset. A recalibrate steps toward the outer edge until the drive reports the track-zero position. A fourth code is rejected as invalid. The block drives one-clock step pulses with a direction line and keeps a count of the present cylinder. When a command ends, it composes the first status byte of the result phase.

When a command ends, the block raises an interrupt request and keeps it raised. A sense strobe then copies the pending status byte and the cylinder into the result outputs and clears the request. The spacing of step pulses is set by a step-rate input, counted in clock cycles. A recalibrate has a fixed budget of step pulses. A relative seek that would leave the valid cylinder range is refused and reported as a fault.

Top module: `fdc_seek_seq`

## Requirements
- R1: After reset, step_pulse, busy and irq are 0, and cyl_now, st0 and res_cyl are all 0.
- R2: cmd_kind 0 is an absolute seek to cylinder cmd_arg. If cmd_arg differs from the cylinder, the block issues |cmd_arg - cylinder| pulses, with step_dir = 1 (toward higher cylinders) when the target is larger and 0 otherwise. At the end, cyl_now equals cmd_arg, status bits 7:6 = 00 (normal) and bit 5 (seek end) = 1.
- R3: Each step pulse lasts one clock. The starts of consecutive pulses are exactly max(step_rate, 2) clocks apart. step_dir holds the same value in the clock before each pulse and during it.
- R4: cmd_kind 1 is a relative seek by cmd_arg cylinders. cmd_outward = 1 moves toward cylinder 0 and 0 moves toward higher cylinders. It issues cmd_arg pulses, cyl_now changes by that amount, and the status shows a normal end with bit 5 set.
- R5: A relative seek whose destination lies below 0 or above 2^CYL_W-1 issues no pulse and leaves the cylinder unchanged. Its status has bits 7:6 = 01 (abnormal), bit 5 = 1 and bit 4 (equipment check) = 1.
- R6: cmd_kind 2 recalibrates. It steps with step_dir = 0, testing trk_zero before each pulse, and stops when trk_zero is 1. The cylinder becomes 0 and the status shows a normal end with bit 5 set.
- R7: If trk_zero is still 0 after 80 recalibrate pulses, the block stops with exactly 80 pulses issued. The status is 01, bit 5 = 1 and bit 4 = 1, and cyl_now is unchanged.
- R8: An absolute seek to the present cylinder, or a relative seek by 0, ends with no pulse, a normal code and bit 5 set.
- R9: cmd_kind 3 is invalid. It issues no pulse, gives status bits 7:6 = 10 with bits 5 and 4 clear, and leaves the cylinder unchanged.
- R10: Status bit 3 is 0. Bit 2 is cmd_head and bits 1:0 are cmd_drive, both as captured when the command was accepted.
- R11: irq rises when a command ends and stays high until sense_go. On sense_go with irq high, st0 and res_cyl load the pending status and cylinder and irq clears. sense_go with irq low changes nothing.
- R12: cmd_go while busy is 1 is ignored and does not alter the running command or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | One-cycle command start strobe |
| cmd_kind | input | 2 | 0 absolute seek, 1 relative seek, 2 recalibrate, 3 invalid |
| cmd_arg | input | CYL_W | Target cylinder or relative offset |
| cmd_outward | input | 1 | Relative seek toward cylinder 0 when 1 |
| cmd_drive | input | 2 | Drive number reported in status |
| cmd_head | input | 1 | Head number reported in status |
| step_rate | input | RATE_W | Clocks between step pulse starts (minimum 2) |
| trk_zero | input | 1 | High when the head sits on cylinder 0 |
| sense_go | input | 1 | Sense strobe: latch result, clear irq |
| step_pulse | output | 1 | One-clock step pulse |
| step_dir | output | 1 | 1 toward higher cylinders, 0 toward cylinder 0 |
| busy | output | 1 | A motion command is in progress |
| irq | output | 1 | Command finished, awaiting sense |
| st0 | output | 8 | Status byte latched by the last sense |
| res_cyl | output | CYL_W | Cylinder latched by the last sense |
| cyl_now | output | CYL_W | Present cylinder |

## Verification
The recalibrate budget edge is tested with the head 80 and 81 cylinders out, and with a drive whose track-zero line never asserts. A design that miscounts would give one pulse too many or too few, or would report success on a head that never reached zero. Relative seeks that would cross cylinder 0 or pass the top cylinder are checked for zero pulses and an unchanged cylinder. A design that clamps or wraps would move the head instead. Step rates of 0 and 1 check the two-clock floor on pulse spacing, and a command strobe sent mid-motion checks that a busy design does not restart. Random mixes of all four command kinds then compare pulse counts, directions, spacing and status bytes against a model written in the bench.

// File: rtl/fdc_seek_pkg.sv
package fdc_seek_pkg;

  typedef enum logic [1:0] {
    K_SEEK  = 2'd0,
    K_REL   = 2'd1,
    K_RECAL = 2'd2,
    K_BAD   = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    TC_NORMAL   = 2'b00,
    TC_ABNORMAL = 2'b01,
    TC_INVALID  = 2'b10,
    TC_POLL     = 2'b11
  } term_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_PREP = 2'd1,
    S_MOVE = 2'd2
  } seq_state_e;

  // status byte: code, seek end, equipment check, zero, head, drive
  function automatic logic [7:0] pack_st0(input term_e tc, input logic se,
                                          input logic ec, input logic head,
                                          input logic [1:0] drv);
    return {tc, se, ec, 1'b0, head, drv};
  endfunction

endpackage

// File: rtl/fdc_seek_plan.sv
module fdc_seek_plan
  import fdc_seek_pkg::*;
#(
  parameter int CYL_W = 8
) (
  input  logic [1:0]       kind,
  input  logic [CYL_W-1:0] arg,
  input  logic             outward,
  input  logic [CYL_W-1:0] cyl,
  output logic             imm,
  output term_e            imm_tc,
  output logic             imm_se,
  output logic             imm_ec,
  output logic             mv_in,
  output logic [CYL_W-1:0] mv_cnt,
  output logic             mv_recal
);

  logic [CYL_W:0] sum_in;

  always_comb begin
    imm      = 1'b0;
    imm_tc   = TC_NORMAL;
    imm_se   = 1'b1;
    imm_ec   = 1'b0;
    mv_in    = 1'b0;
    mv_cnt   = '0;
    mv_recal = 1'b0;
    sum_in   = {1'b0, cyl} + {1'b0, arg};
    case (cmd_kind_e'(kind))
      K_SEEK: begin
        if (arg == cyl) begin
          imm = 1'b1;
        end else begin
          mv_in  = (arg > cyl);
          mv_cnt = (arg > cyl) ? (arg - cyl) : (cyl - arg);
        end
      end
      K_REL: begin
        if (arg == '0) begin
          imm = 1'b1;
        end else if (outward) begin
          if (arg > cyl) begin
            imm    = 1'b1;
            imm_tc = TC_ABNORMAL;
            imm_ec = 1'b1;
          end else begin
            mv_cnt = arg;
          end
        end else begin
          if (sum_in[CYL_W]) begin
            imm    = 1'b1;
            imm_tc = TC_ABNORMAL;
            imm_ec = 1'b1;
          end else begin
            mv_in  = 1'b1;
            mv_cnt = arg;
          end
        end
      end
      K_RECAL: begin
        mv_recal = 1'b1;
      end
      default: begin
        imm    = 1'b1;
        imm_tc = TC_INVALID;
        imm_se = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/fdc_step_timer.sv
module fdc_step_timer #(
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              fire,
  input  logic [RATE_W-1:0] rate,
  output logic              due
);

  logic [RATE_W-1:0] cnt_q;

  // clocks to wait after a pulse; the interval never drops below two
  function automatic logic [RATE_W-1:0] reload_of(input logic [RATE_W-1:0] r);
    return (r < RATE_W'(2)) ? RATE_W'(1) : (r - RATE_W'(1));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (restart) begin
      cnt_q <= '0;
    end else if (fire) begin
      cnt_q <= reload_of(rate);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - RATE_W'(1);
    end
  end

  assign due = (cnt_q == '0);

endmodule

// File: rtl/fdc_seek_seq.sv
module fdc_seek_seq
  import fdc_seek_pkg::*;
#(
  parameter int CYL_W        = 8,
  parameter int RATE_W       = 8,
  parameter int RECAL_BUDGET = 80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_go,
  input  logic [1:0]        cmd_kind,
  input  logic [CYL_W-1:0]  cmd_arg,
  input  logic              cmd_outward,
  input  logic [1:0]        cmd_drive,
  input  logic              cmd_head,
  input  logic [RATE_W-1:0] step_rate,
  input  logic              trk_zero,
  input  logic              sense_go,
  output logic              step_pulse,
  output logic              step_dir,
  output logic              busy,
  output logic              irq,
  output logic [7:0]        st0,
  output logic [CYL_W-1:0]  res_cyl,
  output logic [CYL_W-1:0]  cyl_now
);

  localparam int PC_W = $clog2(RECAL_BUDGET + 1);
  localparam logic [PC_W-1:0] BUDGET_V = PC_W'(RECAL_BUDGET);

  seq_state_e       state_q;
  logic             dir_q, recal_q, head_q, irq_q;
  logic [1:0]       drv_q;
  logic [CYL_W-1:0] remain_q, cyl_q, res_cyl_q;
  logic [PC_W-1:0]  npulse_q;
  logic [7:0]       pend_q, res_q;

  logic             pl_imm, pl_se, pl_ec, pl_in, pl_recal;
  term_e            pl_tc;
  logic [CYL_W-1:0] pl_cnt;

  // named events, shared with the checker
  logic accept, in_move, due, budget_spent;
  logic step_fire, recal_hit, recal_out, seek_last;
  logic done_evt, fault_evt, recal_ok_evt, seek_mode;
  logic [7:0] done_word;

  fdc_seek_plan #(.CYL_W(CYL_W)) u_plan (
    .kind     (cmd_kind),
    .arg      (cmd_arg),
    .outward  (cmd_outward),
    .cyl      (cyl_q),
    .imm      (pl_imm),
    .imm_tc   (pl_tc),
    .imm_se   (pl_se),
    .imm_ec   (pl_ec),
    .mv_in    (pl_in),
    .mv_cnt   (pl_cnt),
    .mv_recal (pl_recal)
  );

  fdc_step_timer #(.RATE_W(RATE_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (state_q == S_PREP),
    .fire    (step_fire),
    .rate    (step_rate),
    .due     (due)
  );

  assign accept       = cmd_go && (state_q == S_IDLE);
  assign in_move      = (state_q == S_MOVE);
  assign budget_spent = (npulse_q == BUDGET_V);
  assign recal_hit    = in_move && due && recal_q && trk_zero;
  assign recal_out    = in_move && due && recal_q && !trk_zero && budget_spent;
  assign step_fire    = in_move && due && !(recal_q && (trk_zero || budget_spent));
  assign seek_last    = step_fire && !recal_q && (remain_q == CYL_W'(1));
  assign done_evt     = (accept && pl_imm) || recal_hit || recal_out || seek_last;
  assign fault_evt    = recal_out || (accept && pl_imm && pl_ec);
  assign recal_ok_evt = recal_hit;
  assign seek_mode    = !recal_q;

  always_comb begin
    done_word = pack_st0(TC_NORMAL, 1'b1, 1'b0, head_q, drv_q);
    if (accept) begin
      done_word = pack_st0(pl_tc, pl_se, pl_ec, cmd_head, cmd_drive);
    end else if (recal_out) begin
      done_word = pack_st0(TC_ABNORMAL, 1'b1, 1'b1, head_q, drv_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= S_IDLE;
      dir_q     <= 1'b0;
      recal_q   <= 1'b0;
      head_q    <= 1'b0;
      drv_q     <= 2'b00;
      irq_q     <= 1'b0;
      remain_q  <= '0;
      cyl_q     <= '0;
      res_cyl_q <= '0;
      npulse_q  <= '0;
      pend_q    <= '0;
      res_q     <= '0;
    end else begin
      if (sense_go && irq_q) begin
        res_q     <= pend_q;
        res_cyl_q <= cyl_q;
        irq_q     <= 1'b0;
      end
      if (done_evt) begin
        pend_q <= done_word;
        irq_q  <= 1'b1;
      end
      case (state_q)
        S_IDLE: begin
          if (accept) begin
            drv_q  <= cmd_drive;
            head_q <= cmd_head;
            if (!pl_imm) begin
              state_q  <= S_PREP;
              dir_q    <= pl_in;
              remain_q <= pl_cnt;
              recal_q  <= pl_recal;
              npulse_q <= '0;
            end
          end
        end
        S_PREP: state_q <= S_MOVE;
        S_MOVE: begin
          if (step_fire) begin
            if (recal_q) begin
              npulse_q <= npulse_q + PC_W'(1);
            end else begin
              remain_q <= remain_q - CYL_W'(1);
              cyl_q    <= dir_q ? (cyl_q + CYL_W'(1)) : (cyl_q - CYL_W'(1));
            end
          end
          if (recal_hit) cyl_q <= '0;
          if (recal_hit || recal_out || seek_last) state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign step_pulse = step_fire;
  assign step_dir   = dir_q;
  assign busy       = (state_q != S_IDLE);
  assign irq        = irq_q;
  assign st0        = res_q;
  assign res_cyl    = res_cyl_q;
  assign cyl_now    = cyl_q;

endmodule

// File: rtl/fdc_seek_chk.sv
module fdc_seek_chk #(
  parameter int CYL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_pulse,
  input logic             step_dir,
  input logic             busy,
  input logic             irq,
  input logic             sense_go,
  input logic [CYL_W-1:0] cyl_now,
  input logic             done_evt,
  input logic             fault_evt,
  input logic             recal_ok_evt,
  input logic             seek_mode
);

  a_r3_pulse_one_wide: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |=> !step_pulse);

  a_r3_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
    step_pulse |-> $stable(step_dir));

  a_r12_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !step_pulse);

  a_r11_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !sense_go) |=> irq);

  a_r11_sense_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && sense_go && !done_evt) |=> !irq);

  a_r5_fault_ends: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> (irq && !busy));

  a_r6_recal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    recal_ok_evt |=> (cyl_now == '0));

  a_r2_inward_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && seek_mode && step_dir) |=> (cyl_now == $past(cyl_now) + CYL_W'(1)));

  a_r4_outward_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && seek_mode && !step_dir) |=> (cyl_now == $past(cyl_now) - CYL_W'(1)));

  a_r7_recal_keeps_cyl: assert property (@(posedge clk) disable iff (!rst_n)
    (step_pulse && !seek_mode) |=> $stable(cyl_now));

endmodule

bind fdc_seek_seq fdc_seek_chk #(.CYL_W(CYL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .step_pulse   (step_pulse),
  .step_dir     (step_dir),
  .busy         (busy),
  .irq          (irq),
  .sense_go     (sense_go),
  .cyl_now      (cyl_now),
  .done_evt     (done_evt),
  .fault_evt    (fault_evt),
  .recal_ok_evt (recal_ok_evt),
  .seek_mode    (seek_mode)
);

// File: tb/sim_fdc_seek_seq.sv
`timescale 1ns/1ps
module sim_fdc_seek_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_go = 1'b0;
  logic [1:0] cmd_kind = 2'd0;
  logic [7:0] cmd_arg = 8'd0;
  logic       cmd_outward = 1'b0;
  logic [1:0] cmd_drive = 2'd0;
  logic       cmd_head = 1'b0;
  logic [7:0] step_rate = 8'd2;
  logic       trk_zero;
  logic       sense_go = 1'b0;
  logic       step_pulse, step_dir, busy, irq;
  logic [7:0] st0, res_cyl, cyl_now;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // drive head model
  int phys = 0;
  bit broken = 1'b0;
  int cyl_m = 0;
  assign trk_zero = !broken && (phys == 0);

  // monitor state
  bit mon_on = 1'b0;
  int pcount, gmin, gmax, last_t, cyc;
  bit wide_err, dir_err, dirv_err, prev_pulse, prev_dir, exp_dir;

  // expectation
  int exp_pulses, exp_cyl;
  logic [7:0] exp_st;

  always #4 clk = ~clk;

  fdc_seek_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_kind(cmd_kind),
    .cmd_arg(cmd_arg), .cmd_outward(cmd_outward), .cmd_drive(cmd_drive),
    .cmd_head(cmd_head), .step_rate(step_rate), .trk_zero(trk_zero),
    .sense_go(sense_go), .step_pulse(step_pulse), .step_dir(step_dir),
    .busy(busy), .irq(irq), .st0(st0), .res_cyl(res_cyl), .cyl_now(cyl_now)
  );

  always @(posedge clk) begin
    if (step_pulse) phys <= step_dir ? phys + 1 : ((phys > 0) ? phys - 1 : 0);
  end

  always @(negedge clk) begin
    if (mon_on && step_pulse) begin
      if (last_t >= 0) begin
        if (cyc - last_t < gmin) gmin = cyc - last_t;
        if (cyc - last_t > gmax) gmax = cyc - last_t;
      end
      if (prev_pulse) wide_err = 1'b1;
      if (step_dir != prev_dir) dir_err = 1'b1;
      if (step_dir != exp_dir) dirv_err = 1'b1;
      last_t = cyc;
      pcount++;
    end
    prev_pulse = step_pulse;
    prev_dir = step_dir;
    cyc++;
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic logic [7:0] mk_st(input logic [1:0] tc, input bit se, input bit ec,
                                       input bit h, input logic [1:0] d);
    logic [7:0] v;
    v = 8'h00;
    v[7:6] = tc; v[5] = se; v[4] = ec; v[2] = h; v[1:0] = d;
    return v;
  endfunction

  // bench model of one command
  task automatic predict(input int kind, input int arg, input bit outw, input bit h,
                         input logic [1:0] d);
    exp_pulses = 0; exp_cyl = cyl_m; exp_dir = 1'b0;
    exp_st = mk_st(2'b00, 1'b1, 1'b0, h, d);
    case (kind)
      0: if (arg != cyl_m) begin
           exp_pulses = (arg > cyl_m) ? arg - cyl_m : cyl_m - arg;
           exp_dir = (arg > cyl_m); exp_cyl = arg;
         end
      1: if (arg != 0) begin
           if (outw) begin
             if (arg > cyl_m) exp_st = mk_st(2'b01, 1'b1, 1'b1, h, d);
             else begin exp_pulses = arg; exp_cyl = cyl_m - arg; end
           end else begin
             if (cyl_m + arg > 255) exp_st = mk_st(2'b01, 1'b1, 1'b1, h, d);
             else begin exp_pulses = arg; exp_cyl = cyl_m + arg; exp_dir = 1'b1; end
           end
         end
      2: if (!broken && phys <= 80) begin exp_pulses = phys; exp_cyl = 0; end
         else begin exp_pulses = 80; exp_st = mk_st(2'b01, 1'b1, 1'b1, h, d); end
      default: exp_st = mk_st(2'b10, 1'b0, 1'b0, h, d);
    endcase
  endtask

  task automatic run_cmd(input int kind, input int arg, input bit outw, input bit h,
                         input logic [1:0] d, input int rate, input string req);
    int n;
    int ival;
    predict(kind, arg, outw, h, d);
    ival = (rate < 2) ? 2 : rate;
    @(negedge clk);
    pcount = 0; gmin = 1000000; gmax = 0; last_t = -1;
    wide_err = 0; dir_err = 0; dirv_err = 0; mon_on = 1'b1;
    cmd_kind = 2'(kind); cmd_arg = 8'(arg); cmd_outward = outw;
    cmd_head = h; cmd_drive = d; step_rate = 8'(rate); cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
    if (busy) begin
      // R12: strobe an invalid command mid-motion; it must be ignored
      cmd_kind = 2'd3; cmd_head = ~h; cmd_drive = ~d; cmd_go = 1'b1;
      @(negedge clk);
      cmd_go = 1'b0;
    end
    n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    check(irq == 1'b1, "R11 irq held until sense", irq, 1);
    check(busy == 1'b0, "R12 not busy after end", busy, 0);
    check(pcount == exp_pulses, {req, " pulse count"}, pcount, exp_pulses);
    check(int'(cyl_now) == exp_cyl, {req, " cylinder"}, cyl_now, exp_cyl);
    if (exp_pulses > 0) begin
      check(!wide_err && !dir_err, "R3 one-clock pulse, steady dir", {wide_err, dir_err}, 0);
      check(!dirv_err, {req, " step direction"}, !exp_dir, exp_dir);
    end
    if (exp_pulses > 1) begin
      check(gmin == ival && gmax == ival, "R3 pulse spacing", gmin * 1000 + gmax, ival * 1001);
    end
    mon_on = 1'b0;
    sense_go = 1'b1;
    @(negedge clk);
    sense_go = 1'b0;
    check(irq == 1'b0, "R11 sense clears irq", irq, 0);
    check(st0 == exp_st, {req, " R10 status byte"}, st0, exp_st);
    check(int'(res_cyl) == exp_cyl, "R11 result cylinder", res_cyl, exp_cyl);
    cyl_m = exp_cyl;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    phys = 37;
    repeat (3) @(negedge clk);
    check(step_pulse == 0 && busy == 0 && irq == 0, "R1 reset outputs",
          {step_pulse, busy, irq}, 0);
    check(st0 == 0 && res_cyl == 0 && cyl_now == 0, "R1 reset values",
          {st0, res_cyl, cyl_now}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_cmd(2, 0, 0, 1, 2'd2, 3, "R6 recal from 37");
    run_cmd(0, 10, 0, 0, 2'd1, 4, "R2 seek to 10");
    run_cmd(0, 10, 0, 1, 2'd3, 4, "R8 seek to same cylinder");
    run_cmd(1, 11, 1, 0, 2'd0, 2, "R5 relative under zero");
    run_cmd(1, 10, 1, 1, 2'd1, 0, "R4 relative outward to 0");
    run_cmd(1, 0, 0, 0, 2'd2, 2, "R8 relative by zero");
    run_cmd(1, 250, 0, 0, 2'd0, 1, "R4 relative inward 250");
    run_cmd(1, 6, 0, 1, 2'd3, 2, "R5 relative past top");
    run_cmd(0, 3, 0, 0, 2'd1, 5, "R2 seek down to 3");
    run_cmd(3, 9, 0, 1, 2'd2, 2, "R9 invalid command");
    phys = 80;
    run_cmd(2, 0, 0, 0, 2'd0, 2, "R6 recal at budget edge 80");
    phys = 81;
    run_cmd(2, 0, 0, 1, 2'd3, 2, "R7 recal 81 out faults");
    broken = 1'b1;
    run_cmd(2, 0, 0, 0, 2'd1, 2, "R7 recal with dead track zero");
    broken = 1'b0;

    // R11: sense without a pending interrupt changes nothing
    sense_go = 1'b1;
    @(negedge clk);
    sense_go = 1'b0;
    @(negedge clk);
    check(st0 == exp_st && irq == 0, "R11 idle sense ignored", st0, exp_st);

    for (int i = 0; i < 30; i++) begin
      int r, kind, arg, rate;
      bit outw;
      r = int'($urandom % 8);
      rate = int'($urandom % 6);
      outw = 1'($urandom % 2);
      if (r < 3) begin kind = 0; arg = int'($urandom % 40); end
      else if (r < 5) begin kind = 1; arg = int'($urandom % 20); end
      else if (r < 7) begin
        kind = 2; arg = 0; phys = int'($urandom % 90);
        broken = (($urandom % 6) == 0);
      end else begin kind = 3; arg = int'($urandom % 256); end
      run_cmd(kind, arg, outw, 1'($urandom % 2), 2'($urandom % 4), rate,
              "R2 R4 R6 R9 random mix");
      broken = 1'b0;
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule